// File: doc/BRIEF.md
# Iterative Round-Robin Switch Allocator

This block pairs the input ports of a 4x4 switch with its output ports for one allocation round. A `start_i` pulse captures a request matrix, where each input names the outputs it holds traffic for. The block then runs a configurable number of grant/accept passes, one per clock. In every pass, each still-free output uses its own round-robin arbiter to offer a grant to one still-free requesting input. Each still-free input then uses its own round-robin arbiter to accept one of the grants it was offered. The accepted pairs are added to the match matrix, and their row and column are masked out of every later pass.

The arbiter priorities move only for arbiters whose chosen winner was actually paired, and only in the first pass of a round. This keeps the rotation fair under load while later passes fill gaps. When the last pass completes, `done_o` pulses and `match_o` holds the result until the next accepted start. The result has at most one bit in any row and at most one bit in any column.

Top module: `rr_sep_alloc`

## Requirements
- R1: `req_i` bit `i*4+j` (input i, output j) is captured on a clock edge where `start_i` is high and the block is idle. Every bit set in `match_o` has its matching captured request bit set.
- R2: `match_o` uses the same bit layout as the requests. It never holds more than one set bit per input row or per output column.
- R3: In each pass, a free output offers its grant to the first free requesting input found when scanning upward from its grant pointer, wrapping from 3 back to 0.
- R4: A free input that holds one or more grants accepts the first offering output found when scanning upward from its accept pointer, with wrap-around. That pair becomes a match.
- R5: Only a first-pass match moves pointers. The granting output's pointer goes to one past the matched input, modulo 4, and the accepting input's pointer goes to one past the matched output, modulo 4. All other pointers keep their values. Passes after the first use the updated pointers. All pointers are 0 after reset.
- R6: Matches made in earlier passes of a round are kept. A later pass can only pair an input and an output that are both still unmatched.
- R7: `busy_o` is high from the edge that accepts a start until the final pass. `done_o` is high for exactly one cycle, ITERS+1 edges after the accepting edge, counting that edge as the first. `match_o` is then stable until the next accepted start.
- R8: A `start_i` pulse while `busy_o` is high is ignored, and the round in progress completes with its original requests.
- R9: With ITERS equal to 4, the final match is maximal: no captured request remains whose input and output are both unmatched.
- R10: After reset, `busy_o`, `done_o` and `match_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Begins an allocation round when the block is idle |
| req_i | input | N*N | Request matrix, bit i*N+j set when input i wants output j |
| busy_o | output | 1 | An allocation round is in progress |
| done_o | output | 1 | One-cycle pulse marking the final match |
| match_o | output | N*N | Match matrix, same layout as the requests |

## Verification
The bench runs a two-pass instance and a four-pass instance side by side and compares both against an arithmetic model that carries the pointer state from one round to the next.

It applies four fixed request patterns:
- An all-ones matrix, where every output targets input 0 and only the diagonal can grow pass by pass.
- An empty matrix.
- A diagonal, which has no conflicts.
- A staircase in which a poor choice blocks two inputs.

Several thousand pseudo-random matrices of varying density follow. They exercise pointer rotation and tell apart a single pass from repeated passes. Some rounds inject an inverted request pattern mid-round to show that a busy round keeps its own requests.

// File: rtl/sa_pkg.sv
package sa_pkg;
  // Increment an index modulo n.
  function automatic int wrap_inc(input int v, input int n);
    return (v >= n - 1) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/sa_rr_arb.sv
// Combinational round-robin pick: first set request at or above ptr.
module sa_rr_arb #(
  parameter int N  = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [PW-1:0] ptr,
  output logic [N-1:0]  gnt,
  output logic [PW-1:0] win_idx,
  output logic          any
);
  always_comb begin
    int idx;
    gnt     = '0;
    win_idx = '0;
    any     = 1'b0;
    for (int k = 0; k < N; k++) begin
      idx = int'(ptr) + k;
      if (idx >= N) idx = idx - N;
      if (!any && req[idx]) begin
        any      = 1'b1;
        gnt[idx] = 1'b1;
        win_idx  = PW'(idx);
      end
    end
  end
endmodule

// File: rtl/sa_iter_stage.sv
// One grant/accept pass over a masked request matrix.
module sa_iter_stage
  import sa_pkg::*;
#(
  parameter int N  = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*N-1:0]         req_m,
  input  logic [N-1:0][PW-1:0]   gptr,
  input  logic [N-1:0][PW-1:0]   aptr,
  output logic [N*N-1:0]         acc,
  output logic [N-1:0]           g_upd,
  output logic [N-1:0][PW-1:0]   g_nxt,
  output logic [N-1:0]           a_upd,
  output logic [N-1:0][PW-1:0]   a_nxt
);
  logic [N-1:0]  col_req [N];
  logic [N-1:0]  ogrant  [N];
  logic [PW-1:0] ow_idx  [N];
  logic [N-1:0]  o_any;
  logic [N-1:0]  in_gnt  [N];
  logic [N-1:0]  iacc    [N];
  logic [PW-1:0] iw_idx  [N];
  logic [N-1:0]  i_any;

  genvar gi, gj;
  generate
    for (gi = 0; gi < N; gi++) begin : g_x
      for (gj = 0; gj < N; gj++) begin : g_y
        assign col_req[gj][gi]   = req_m[gi*N+gj];
        assign in_gnt[gi][gj]    = ogrant[gj][gi];
        assign acc[gi*N+gj]      = iacc[gi][gj];
      end
    end

    for (gj = 0; gj < N; gj++) begin : g_out
      sa_rr_arb #(.N(N)) u_oarb (
        .req     (col_req[gj]),
        .ptr     (gptr[gj]),
        .gnt     (ogrant[gj]),
        .win_idx (ow_idx[gj]),
        .any     (o_any[gj])
      );
      logic [N-1:0] col_acc;
      for (gi = 0; gi < N; gi++) begin : g_c
        assign col_acc[gi] = iacc[gi][gj];
      end
      assign g_upd[gj] = o_any[gj] && (|col_acc);
      assign g_nxt[gj] = PW'(wrap_inc(int'(ow_idx[gj]), N));
    end

    for (gi = 0; gi < N; gi++) begin : g_in
      sa_rr_arb #(.N(N)) u_iarb (
        .req     (in_gnt[gi]),
        .ptr     (aptr[gi]),
        .gnt     (iacc[gi]),
        .win_idx (iw_idx[gi]),
        .any     (i_any[gi])
      );
      assign a_upd[gi] = i_any[gi];
      assign a_nxt[gi] = PW'(wrap_inc(int'(iw_idx[gi]), N));
    end
  endgenerate
endmodule

// File: rtl/sa_ptr_bank.sv
// Bank of N round-robin pointers with per-entry update enables.
module sa_ptr_bank #(
  parameter int N  = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [N-1:0]         upd,
  input  logic [N-1:0][PW-1:0] nxt,
  output logic [N-1:0][PW-1:0] ptr
);
  genvar gk;
  generate
    for (gk = 0; gk < N; gk++) begin : g_p
      logic          ld;
      logic [PW-1:0] d;
      always_comb begin
        ld = en && upd[gk];
        d  = ld ? nxt[gk] : ptr[gk];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  ptr[gk] <= '0;
        else if (ld) ptr[gk] <= d;
      end
    end
  endgenerate
endmodule

// File: rtl/rr_sep_alloc.sv
// Iterative separable allocator with round-robin output and input arbiters.
module rr_sep_alloc #(
  parameter int N     = 4,
  parameter int ITERS = 2,
  localparam int PW   = (N > 1) ? $clog2(N) : 1,
  localparam int CW   = (ITERS > 1) ? $clog2(ITERS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [N*N-1:0] req_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [N*N-1:0] match_o
);
  // Reset: asynchronous assert, synchronous release.
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  logic           busy_q, busy_d;
  logic           done_q, done_d;
  logic [CW-1:0]  iter_q, iter_d;
  logic [N*N-1:0] req_q, req_d;
  logic [N*N-1:0] match_q, match_d;
  logic           accept_start, last_pass, first_pass;
  logic           iter_en, match_en;

  logic [N-1:0]         row_used, col_used;
  logic [N*N-1:0]       req_m, acc;
  logic [N-1:0]         g_upd, a_upd;
  logic [N-1:0][PW-1:0] g_nxt, a_nxt, gptr, aptr;

  // Remove rows and columns already paired in this round.
  genvar gr, gc;
  generate
    for (gr = 0; gr < N; gr++) begin : g_row
      assign row_used[gr] = |match_q[gr*N +: N];
    end
    for (gc = 0; gc < N; gc++) begin : g_col
      logic [N-1:0] cv;
      for (gr = 0; gr < N; gr++) begin : g_cb
        assign cv[gr] = match_q[gr*N+gc];
      end
      assign col_used[gc] = |cv;
    end
    for (gr = 0; gr < N; gr++) begin : g_mr
      for (gc = 0; gc < N; gc++) begin : g_mc
        assign req_m[gr*N+gc] = req_q[gr*N+gc] && !row_used[gr] && !col_used[gc];
      end
    end
  endgenerate

  sa_iter_stage #(.N(N)) u_stage (
    .req_m (req_m),
    .gptr  (gptr),
    .aptr  (aptr),
    .acc   (acc),
    .g_upd (g_upd),
    .g_nxt (g_nxt),
    .a_upd (a_upd),
    .a_nxt (a_nxt)
  );

  sa_ptr_bank #(.N(N)) u_gptr (
    .clk (clk), .rst_n (rs_n), .en (first_pass),
    .upd (g_upd), .nxt (g_nxt), .ptr (gptr)
  );

  sa_ptr_bank #(.N(N)) u_aptr (
    .clk (clk), .rst_n (rs_n), .en (first_pass),
    .upd (a_upd), .nxt (a_nxt), .ptr (aptr)
  );

  // Next-state logic.
  always_comb begin
    accept_start = start_i && !busy_q;
    last_pass    = busy_q && (iter_q == CW'(ITERS - 1));
    first_pass   = busy_q && (iter_q == '0);
    iter_en      = accept_start || busy_q;
    match_en     = accept_start || busy_q;

    busy_d  = busy_q;
    done_d  = 1'b0;
    iter_d  = iter_q;
    req_d   = req_q;
    match_d = match_q;

    if (accept_start) begin
      busy_d  = 1'b1;
      iter_d  = '0;
      req_d   = req_i;
      match_d = '0;
    end else if (busy_q) begin
      match_d = match_q | acc;
      if (last_pass) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        iter_d = iter_q + 1'b1;
      end
    end
  end

  // Registers.
  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n)          iter_q <= '0;
    else if (iter_en)   iter_q <= iter_d;
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n)             req_q <= '0;
    else if (accept_start) req_q <= req_d;
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n)         match_q <= '0;
    else if (match_en) match_q <= match_d;
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign match_o = match_q;

  // Checks kept next to the logic they guard.
  AST_MATCH_IN_REQ: assert property (@(posedge clk) disable iff (!rs_n)
    (match_q & ~req_q) == '0); // R1

  generate
    for (gr = 0; gr < N; gr++) begin : g_ast_row
      AST_ROW_ONE: assert property (@(posedge clk) disable iff (!rs_n)
        $onehot0(match_q[gr*N +: N])); // R2
    end
    for (gc = 0; gc < N; gc++) begin : g_ast_col
      AST_COL_ONE: assert property (@(posedge clk) disable iff (!rs_n)
        $onehot0(g_col[gc].cv)); // R2
    end
  endgenerate

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rs_n)
    (busy_q && iter_q != '0) |=> ($stable(gptr) && $stable(aptr))); // R5

  AST_MATCH_KEEP: assert property (@(posedge clk) disable iff (!rs_n)
    busy_q |=> ((match_q & $past(match_q)) == $past(match_q))); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rs_n)
    done_q |=> !done_q); // R7

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rs_n)
    $rose(done_q) |-> $fell(busy_q)); // R7

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rs_n)
    (busy_q && start_i) |=> $stable(req_q)); // R8
endmodule

// File: tb/rr_sep_alloc_bench.sv
`timescale 1ns/1ps
module rr_sep_alloc_bench;
  localparam int N   = 4;
  localparam int ITA = 2;
  localparam int ITB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] req_i = '0;
  logic        busy_a, done_a, busy_b, done_b;
  logic [15:0] match_a, match_b;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rr_sep_alloc #(.N(N), .ITERS(ITA)) u_rr_sep_alloc (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .req_i (req_i),
    .busy_o (busy_a), .done_o (done_a), .match_o (match_a)
  );

  rr_sep_alloc #(.N(N), .ITERS(ITB)) u_rr_sep_alloc_full (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .req_i (req_i),
    .busy_o (busy_b), .done_o (done_b), .match_o (match_b)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference: pointers packed 2 bits per port, returns {gp, ap, match}.
  function automatic logic [31:0] model(input logic [15:0] rq, input logic [7:0] gp,
                                        input logic [7:0] ap, input int its);
    logic [15:0] m, mn;
    logic [7:0]  ng, na;
    int          gw [4];
    m = '0;
    for (int it = 0; it < its; it++) begin
      mn = m; ng = gp; na = ap;
      for (int j = 0; j < 4; j++) begin
        gw[j] = -1;
        if ((m[j] | m[4+j] | m[8+j] | m[12+j]) == 1'b0) begin
          for (int k = 0; k < 4; k++) begin
            int i;
            i = (int'(gp[j*2 +: 2]) + k) % 4;
            if (gw[j] < 0 && rq[i*4+j] && m[i*4 +: 4] == 4'b0) gw[j] = i;
          end
        end
      end
      for (int i = 0; i < 4; i++) begin
        bit found;
        found = 1'b0;
        if (m[i*4 +: 4] == 4'b0) begin
          for (int k = 0; k < 4; k++) begin
            int j;
            j = (int'(ap[i*2 +: 2]) + k) % 4;
            if (!found && gw[j] == i) begin
              found = 1'b1;
              mn[i*4+j] = 1'b1;
              if (it == 0) begin
                ng[j*2 +: 2] = 2'((i + 1) % 4);
                na[i*2 +: 2] = 2'((j + 1) % 4);
              end
            end
          end
        end
      end
      m = mn; gp = ng; ap = na;
    end
    return {gp, ap, m};
  endfunction

  function automatic bit one_per_line(input logic [15:0] m);
    for (int i = 0; i < 4; i++) begin
      if ($countones(m[i*4 +: 4]) > 1) return 1'b0;
      if ($countones({m[i], m[4+i], m[8+i], m[12+i]}) > 1) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic bit maximal(input logic [15:0] rq, input logic [15:0] m);
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        if (rq[i*4+j] && m[i*4 +: 4] == 4'b0 && {m[j], m[4+j], m[8+j], m[12+j]} == 4'b0)
          return 1'b0;
    return 1'b1;
  endfunction

  logic [7:0] gpa = '0, apa = '0, gpb = '0, apb = '0;

  task automatic run(input logic [15:0] rq, input bit inject, input bit lit, input logic [15:0] la, input logic [15:0] lb);
    logic [31:0] ea, eb;
    ea = model(rq, gpa, apa, ITA);
    eb = model(rq, gpb, apb, ITB);
    gpa = ea[31:24]; apa = ea[23:16];
    gpb = eb[31:24]; apb = eb[23:16];
    @(negedge clk); req_i = rq; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(busy_a && busy_b && !done_a && !done_b, "R7 busy after start", {busy_a, busy_b, done_a, done_b}, 4'b1100);
    if (inject) begin start_i = 1'b1; req_i = ~rq; end
    @(negedge clk); start_i = 1'b0;
    chk(!done_a, "R7 no early done", done_a, 0);
    @(negedge clk);
    chk(done_a && !busy_a, "R7 done A", {done_a, busy_a}, 2'b10);
    chk(match_a == ea[15:0], "R3 R4 R5 R6 R8 match A", match_a, ea[15:0]);
    chk((match_a & ~rq) == 0 && one_per_line(match_a), "R1 R2 A", match_a, rq);
    if (lit) chk(match_a == la, "R3 literal A", match_a, la);
    @(negedge clk);
    chk(!done_a && match_a == ea[15:0], "R7 pulse and hold A", {done_a, match_a}, {1'b0, ea[15:0]});
    chk(!done_b, "R7 no early done B", done_b, 0);
    @(negedge clk);
    chk(done_b && !busy_b, "R7 done B", {done_b, busy_b}, 2'b10);
    chk(match_b == eb[15:0], "R5 R6 R8 match B", match_b, eb[15:0]);
    chk(maximal(rq, match_b), "R9 maximal B", match_b, rq);
    chk((match_b & ~rq) == 0 && one_per_line(match_b), "R1 R2 B", match_b, rq);
    if (lit) chk(match_b == lb, "R4 literal B", match_b, lb);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_a && !done_a && match_a == 0 && !busy_b && !done_b && match_b == 0,
        "R10 reset state", {busy_a, done_a, match_a}, 0);
    // All-ones from reset pointers: diagonal grows one pair per pass.
    run(16'hFFFF, 1'b0, 1'b1, 16'h0021, 16'h8421);
    run(16'h0000, 1'b0, 1'b1, 16'h0000, 16'h0000);
    run(16'h8421, 1'b0, 1'b1, 16'h8421, 16'h8421);
    run(16'h8C63, 1'b1, 1'b0, 16'h0, 16'h0);
    run(16'hFFFF, 1'b1, 1'b0, 16'h0, 16'h0);
    lf = 16'hACE1;
    for (int v = 0; v < 4000; v++) begin
      logic [15:0] rq;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (v % 3)
        0: rq = lf;
        1: rq = lf & {lf[7:0], lf[15:8]};
        default: rq = lf | {lf[3:0], lf[15:4]};
      endcase
      run(rq, (v % 7) == 0, 1'b0, 16'h0, 16'h0);
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule